// File: doc/BRIEF.md
# Read Burst Data Window and Bus Termination Sequencer

This block sits on the controller side of a double-data-rate memory read path. A READ command is sampled together with a CAS latency and a burst-length select. The block then schedules the clock cycles in which read data is to be captured. Each data beat takes half a clock, so a four-beat burst fills two clock cycles and an eight-beat burst fills four. Starting columns are aligned to four beats, so the two lowest column bits play no part in the schedule.

The block also drives the line controls around each burst. Termination is released one cycle before the first beat. The bus is driven high for one cycle once a burst ends with no data right behind it, and termination comes back in the cycle after that. When bursts follow each other with no idle cycle between them, they form one continuous window: termination stays off and no high pulse appears at the seam. A READ accepted while earlier bursts are still waiting is placed in a shift-register timeline as deep as the longest latency plus the longest burst. A separate flag tells the command scheduler whether a PRECHARGE may be issued in the current cycle.

Top module: `rd_burst_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, data_valid and bus_hi are 0 and term_en and pre_ok are 1.
- R2: For a READ sampled at the clock edge that ends cycle r, data_valid first goes high in cycle r+L, where L is the effective CAS latency.
- R3: burst_sel=0 selects four beats, and data_valid is then high for 2 consecutive cycles. burst_sel=1 selects eight beats, and data_valid is then high for 4 consecutive cycles.
- R4: term_en is low in every cycle that carries data, in the cycle just before each burst, and in the cycle just after each burst. It is high in all other cycles unless R7 applies.
- R5: bus_hi is high for exactly one cycle: the first cycle without data that follows a cycle with data. It is low in all other cycles.
- R6: Back-to-back READs whose data windows touch produce one unbroken data_valid window. term_en stays low across the seam and bus_hi does not pulse there.
- R7: While dterm_off is high, term_en is low in that same cycle, whatever the read activity.
- R8: A cas_lat value below 3 is treated as 3, and a value above 12 is treated as 12.
- R9: pre_ok is low in the cycle right after a READ is sampled and high in all other cycles. A PRECHARGE is therefore never allowed earlier than two cycles after a READ.
- R10: Each READ keeps the latency and burst length that were sampled with it. A READ accepted while earlier bursts are still pending gets its own window, even if that window comes before an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | READ command, sampled at the rising edge |
| burst_sel | input | 1 | 0 = four beats, 1 = eight beats; sampled together with rd_cmd |
| cas_lat | input | 4 | CAS latency in cycles; sampled together with rd_cmd |
| dterm_off | input | 1 | Forces termination off while high |
| data_valid | output | 1 | High in each cycle in which read data is to be captured |
| term_en | output | 1 | Termination enable for the data lines |
| bus_hi | output | 1 | One-cycle pulse that drives the bus high after a burst |
| pre_ok | output | 1 | A PRECHARGE may be issued in this cycle |

## Verification
All results are counted from the cycle r in which the READ is presented. data_valid rises in cycle r+L after L register stages. term_en falls one cycle earlier, in cycle r+L-1. pre_ok is low only in cycle r+1. bus_hi and the return of term_en come one and two cycles after the last data cycle. The bench keeps an absolute cycle index and writes the expected data cycles into a table when each READ is issued. At every falling edge it derives the expected term_en, bus_hi and pre_ok from that table, from the neighbouring cycles and from dterm_off, then compares them with the outputs. Every output is therefore checked in every cycle, including at burst seams and at latency limits.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  // clock cycles taken by a burst (two beats per clock)
  localparam int unsigned SHORT_CYC = 2;
  localparam int unsigned LONG_CYC  = 4;

  typedef enum logic {
    BURST_SHORT = 1'b0,
    BURST_LONG  = 1'b1
  } burst_e;
endpackage

// File: rtl/rbs_window_gen.sv
module rbs_window_gen
  import rbs_pkg::*;
#(
  parameter int CL_W   = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 12,
  parameter int DEPTH  = 16
) (
  input  logic [CL_W-1:0]  cas_lat,
  input  logic             burst_sel,
  output logic [DEPTH-1:0] win
);
  localparam int IW_A = CL_W + 2;
  localparam int IW_B = $clog2(DEPTH) + 1;
  localparam int IW   = (IW_A > IW_B) ? IW_A : IW_B;

  logic [CL_W-1:0] cl_eff;
  logic [IW-1:0]   lo;
  logic [IW-1:0]   hi;
  burst_e          kind;

  always_comb begin
    if (cas_lat < CL_W'(CL_MIN))      cl_eff = CL_W'(CL_MIN);
    else if (cas_lat > CL_W'(CL_MAX)) cl_eff = CL_W'(CL_MAX);
    else                              cl_eff = cas_lat;
  end

  assign kind = burst_e'(burst_sel);

  // slot 0 after the sampling edge is cycle r+1, so first data sits at L-1
  always_comb begin
    lo = IW'(cl_eff) - IW'(1);
    hi = lo + ((kind == BURST_LONG) ? IW'(LONG_CYC) : IW'(SHORT_CYC));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign win[i] = (IW'(i) >= lo) && (IW'(i) < hi);
  end
endmodule

// File: rtl/rbs_timeline.sv
module rbs_timeline #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DEPTH-1:0] win,
  output logic             now,
  output logic             soon
);
  logic [DEPTH-1:0] slot_q;
  logic [DEPTH-1:0] slot_d;

  always_comb begin
    slot_d = {1'b0, slot_q[DEPTH-1:1]};
    if (load) slot_d = slot_d | win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign now  = slot_q[0];
  assign soon = slot_q[1];
endmodule

// File: rtl/rbs_bus_ctrl.sv
module rbs_bus_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic now,
  input  logic soon,
  input  logic rd_cmd,
  input  logic dterm_off,
  output logic term_en,
  output logic bus_hi,
  output logic pre_ok
);
  logic was_q, was_d;
  logic rd_q, rd_d;

  always_comb begin
    was_d = now;
    rd_d  = rd_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      was_q <= was_d;
      rd_q  <= rd_d;
    end
  end

  assign term_en = ~(now | soon | was_q | dterm_off);
  assign bus_hi  = was_q & ~now;
  assign pre_ok  = ~rd_q;
endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
  import rbs_pkg::*;
#(
  parameter int CL_W   = 4,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_cmd,
  input  logic            burst_sel,
  input  logic [CL_W-1:0] cas_lat,
  input  logic            dterm_off,
  output logic            data_valid,
  output logic            term_en,
  output logic            bus_hi,
  output logic            pre_ok
);
  localparam int DEPTH = CL_MAX + LONG_CYC;

  logic [DEPTH-1:0] win;
  logic             now, soon;

  rbs_window_gen #(.CL_W(CL_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .DEPTH(DEPTH)) u_win (
    .cas_lat   (cas_lat),
    .burst_sel (burst_sel),
    .win       (win)
  );

  rbs_timeline #(.DEPTH(DEPTH)) u_tl (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_cmd),
    .win   (win),
    .now   (now),
    .soon  (soon)
  );

  rbs_bus_ctrl u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .now       (now),
    .soon      (soon),
    .rd_cmd    (rd_cmd),
    .dterm_off (dterm_off),
    .term_en   (term_en),
    .bus_hi    (bus_hi),
    .pre_ok    (pre_ok)
  );

  assign data_valid = now;
endmodule

// File: rtl/rd_burst_seq_chk.sv
module rd_burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_cmd,
  input logic dterm_off,
  input logic data_valid,
  input logic term_en,
  input logic bus_hi,
  input logic pre_ok
);
  // R4
  term_off_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !term_en);

  // R4
  term_off_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(!term_en));

  // R4
  term_off_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> !term_en);

  // R5
  bus_hi_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hi |-> ($past(data_valid) && !data_valid));

  // R7
  dterm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dterm_off |-> !term_en);

  // R9
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_cmd) |-> !pre_ok);
endmodule

bind rd_burst_seq rd_burst_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_cmd     (rd_cmd),
  .dterm_off  (dterm_off),
  .data_valid (data_valid),
  .term_en    (term_en),
  .bus_hi     (bus_hi),
  .pre_ok     (pre_ok)
);

// File: tb/rd_burst_seq_test.sv
module rd_burst_seq_test;
  logic       clk;
  logic       rst_n;
  logic       rd_cmd;
  logic       burst_sel;
  logic [3:0] cas_lat;
  logic       dterm_off;
  logic       data_valid, term_en, bus_hi, pre_ok;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit exp_dv [0:4095];
  bit rd_at  [0:4095];

  rd_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .burst_sel(burst_sel),
    .cas_lat(cas_lat), .dterm_off(dterm_off), .data_valid(data_valid),
    .term_en(term_en), .bus_hi(bus_hi), .pre_ok(pre_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
    end
  endtask

  // called just after a falling edge: check this cycle, then move to the next falling edge
  task automatic step(input string tag);
    bit dv, pv, nv, et, eb, ep;
    dv = exp_dv[cyc];
    pv = (cyc > 0) ? exp_dv[cyc-1] : 1'b0;
    nv = exp_dv[cyc+1];
    ep = (cyc > 0) ? !rd_at[cyc-1] : 1'b1;
    et = !(dv | nv | pv | dterm_off);
    eb = pv & !dv;
    #1;
    chk(tag, "data_valid", data_valid, dv);
    chk(dterm_off ? "R7" : "R4", "term_en", term_en, et);
    chk("R5", "bus_hi", bus_hi, eb);
    chk("R9", "pre_ok", pre_ok, ep);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic issue(input logic b8, input int cl, input string tag);
    int eff, n;
    eff = (cl < 3) ? 3 : ((cl > 12) ? 12 : cl);
    n   = b8 ? 4 : 2;
    for (int k = 0; k < n; k++) exp_dv[cyc+eff+k] = 1'b1;
    rd_at[cyc] = 1'b1;
    rd_cmd = 1'b1; burst_sel = b8; cas_lat = 4'(cl);
    step(tag);
    rd_cmd = 1'b0; burst_sel = ~b8; cas_lat = 4'(15 - cl);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rd_cmd = 1'b0; burst_sel = 1'b0; cas_lat = 4'd7; dterm_off = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "data_valid", data_valid, 1'b0);
    chk("R1", "term_en", term_en, 1'b1);
    chk("R1", "bus_hi", bus_hi, 1'b0);
    chk("R1", "pre_ok", pre_ok, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3, "R1");
  endtask

  task automatic t_single(input logic b8, input int cl, input string tag);
    issue(b8, cl, tag);
    idle(cl + 8, tag);
  endtask

  task automatic t_gapless;
    issue(1'b0, 7, "R6");
    step("R6");
    issue(1'b0, 7, "R6");   // windows touch
    idle(16, "R6");
  endtask

  task automatic t_gap;
    issue(1'b0, 6, "R5");
    step("R5");
    step("R5");
    issue(1'b0, 6, "R5");   // one empty cycle between bursts
    idle(14, "R5");
  endtask

  task automatic t_queue;
    issue(1'b0, 9, "R10");
    issue(1'b0, 5, "R10");  // later read lands first
    issue(1'b1, 12, "R10");
    idle(20, "R10");
  endtask

  task automatic t_dterm;
    dterm_off = 1'b1;
    idle(3, "R7");
    issue(1'b1, 6, "R7");
    idle(12, "R7");
    dterm_off = 1'b0;
    idle(3, "R7");
  endtask

  task automatic t_clamp;
    issue(1'b0, 0, "R8");
    idle(8, "R8");
    issue(1'b1, 15, "R8");
    idle(20, "R8");
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin exp_dv[i] = 1'b0; rd_at[i] = 1'b0; end
    t_reset();
    t_single(1'b0, 7, "R2,R3");
    t_single(1'b1, 8, "R2,R3");
    t_single(1'b0, 3, "R2");
    t_gapless();
    t_gap();
    t_queue();
    t_dterm();
    t_clamp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule